// File: doc/BRIEF.md
# Modem Control and Loopback Status Register Pair

This block keeps the modem control register and the modem status register of a 16550-compatible serial port. Software writes the control byte through a write strobe. It reads the status byte back, and a read strobe marks the access. The control byte drives a loopback flag that the receive path consumes. In loopback mode, the block discards bytes from the external receive source before they reach any buffer.

The upper nibble of the status register carries the live line states. In loopback they come from control bits. Outside loopback they take a fixed idle pattern in which carrier-detect and data-set-ready are asserted. The lower nibble carries sticky change flags. Only control-register writes that alter the derived line states set these flags. A status read clears them. Their OR goes to the interrupt logic as a single pending flag.

Top module: `mdm_loopback_status`

## Requirements
- R1: A control write stores only bits 4:0 of `wdata`: bit 0 DTR, bit 1 RTS, bit 2 OUT1, bit 3 OUT2, bit 4 loopback. `ctl_q[7:5]` always reads zero, and `ctl_q` shows the new value in the cycle after the strobe.
- R2: With loopback set, the upper status nibble follows the control bits in the cycle after the write: bit 4 (CTS) = RTS, bit 5 (DSR) = DTR, bit 6 (RI) = OUT1, bit 7 (DCD) = OUT2.
- R3: With loopback clear, a control write makes the upper status nibble 4'b1010, meaning DCD and DSR set and CTS and RI clear.
- R4: When a control write changes derived CTS, DSR or DCD, it sets the matching change flag: bit 0 for CTS, bit 1 for DSR, bit 3 for DCD.
- R5: Status bit 2 (trailing-edge ring flag) is set only when derived RI goes from 1 to 0. A rise or no change leaves it untouched.
- R6: Change flags accumulate across writes and stay set until a status read.
- R7: During a `sts_rd` cycle, `sts_q` shows the full byte. From the next cycle, all four change flags are zero. A flag raised by a control write in that same cycle still appears.
- R8: While `loopback_o` is 1, `rx_valid_o` is 0 and `rx_data_o` is zero. Otherwise the external byte and its valid pass straight through.
- R9: A `sts_wr` strobe changes neither register.
- R10: `delta_pend_o` is 1 exactly when any of status bits 3:0 is set.
- R11: After reset, `ctl_q` holds the reset control value (default 0x00). `sts_q` holds the status derived from it with no change flags set (0xA0 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| sts_wr | input | 1 | Status register write strobe (ignored) |
| sts_rd | input | 1 | Status register read strobe; clears change flags |
| wdata | input | 8 | Write data byte |
| rx_valid_i | input | 1 | External receive byte valid |
| rx_data_i | input | DATA_W | External receive byte |
| ctl_q | output | 8 | Control register readback |
| sts_q | output | 8 | Status register readback |
| loopback_o | output | 1 | Loopback mode flag to the receive path |
| delta_pend_o | output | 1 | Any change flag set |
| rx_valid_o | output | 1 | Receive byte valid after loopback gating |
| rx_data_o | output | DATA_W | Receive byte after loopback gating |

## Verification
A wrong stored live nibble shows in `sts_q[7:4]` in the cycle after the control write that caused it. It also produces wrong change flags on the next write, because each flag comes from comparing the old and new nibble. A change flag that is lost or stuck shows at once in `sts_q[3:0]` and `delta_pend_o`. It never waits for a later event, since every register drives its readback directly. A bad loopback flag shows at once as leaked or missing receive bytes. The bench keeps a behavioural model in step every clock, so any of these faults shows up within one cycle of the access that caused it.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

    localparam int REG_W  = 8;
    localparam int CTRL_W = 5;

    typedef struct packed {
        logic [REG_W-CTRL_W-1:0] rsvd;
        logic loop;
        logic out2;
        logic out1;
        logic rts;
        logic dtr;
    } ctrl_t;

    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } live_t;

    typedef struct packed {
        logic ddcd;
        logic teri;
        logic ddsr;
        logic dcts;
    } delta_t;

    localparam live_t LIVE_IDLE = '{dcd: 1'b1, ri: 1'b0, dsr: 1'b1, cts: 1'b0};

    function automatic ctrl_t mask_ctrl(input logic [REG_W-1:0] raw);
        ctrl_t c;
        c      = ctrl_t'(raw);
        c.rsvd = '0;
        return c;
    endfunction

    function automatic live_t derive_live(input ctrl_t c);
        live_t l;
        if (c.loop) begin
            l.cts = c.rts;
            l.dsr = c.dtr;
            l.ri  = c.out1;
            l.dcd = c.out2;
        end else begin
            l = LIVE_IDLE;
        end
        return l;
    endfunction

    function automatic delta_t change_flags(input live_t prev, input live_t nxt);
        delta_t d;
        d.dcts = prev.cts ^ nxt.cts;
        d.ddsr = prev.dsr ^ nxt.dsr;
        d.ddcd = prev.dcd ^ nxt.dcd;
        d.teri = prev.ri & ~nxt.ri;
        return d;
    endfunction

endpackage

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
    import mdm_pkg::*;
#(
    parameter logic [CTRL_W-1:0] RESET_CTRL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output ctrl_t            nxt,
    output ctrl_t            q
);

    localparam ctrl_t RESET_VAL = ctrl_t'({{(REG_W-CTRL_W){1'b0}}, RESET_CTRL});

    always_comb nxt = mask_ctrl(wdata);

    always_ff @(posedge clk) begin
        if (rst)     q <= RESET_VAL;
        else if (wr) q <= nxt;
    end

    // R1: stored value is the masked write data
    p_ctrl_store_r1: assert property (@(posedge clk) disable iff (rst)
        wr |=> (q == ctrl_t'({{(REG_W-CTRL_W){1'b0}}, $past(wdata[CTRL_W-1:0])})));

    // R1: reserved bits never read as one
    p_ctrl_rsvd_r1: assert property (@(posedge clk) disable iff (rst)
        !wr |=> (q.rsvd == '0));

endmodule

// File: rtl/mdm_status_reg.sv
module mdm_status_reg
    import mdm_pkg::*;
#(
    parameter logic [CTRL_W-1:0] RESET_CTRL = '0
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   ctl_wr,
    input  ctrl_t  ctl_nxt,
    input  logic   sts_rd,
    output live_t  live_q,
    output delta_t delta_q,
    output logic   pend
);

    localparam ctrl_t RESET_CTRL_VAL = ctrl_t'({{(REG_W-CTRL_W){1'b0}}, RESET_CTRL});
    localparam live_t RESET_LIVE     = derive_live(RESET_CTRL_VAL);

    live_t  live_new;
    delta_t delta_hit;
    delta_t delta_kept;
    delta_t delta_next;

    always_comb begin
        live_new   = derive_live(ctl_nxt);
        delta_hit  = ctl_wr ? change_flags(live_q, live_new) : '0;
        delta_kept = sts_rd ? '0 : delta_q;
        delta_next = delta_kept | delta_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q  <= RESET_LIVE;
            delta_q <= '0;
        end else begin
            if (ctl_wr) live_q <= live_new;
            delta_q <= delta_next;
        end
    end

    always_comb pend = |delta_q;

    // R3: outside loopback the idle pattern is shown
    p_idle_live_r3: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !ctl_nxt.loop) |=> (live_q == LIVE_IDLE));

    // R5: rising or steady ring never raises the trailing-edge flag
    p_teri_fall_only_r5: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !sts_rd && !live_q.ri && !delta_q.teri) |=> !delta_q.teri);

    // R6: without a read, flags are sticky
    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        !sts_rd |=> ((delta_q | $past(delta_q)) == delta_q));

    // R7: a read with no write leaves no flag
    p_read_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (sts_rd && !ctl_wr) |=> (delta_q == '0));

    // R4: live nibble unchanged without a control write
    p_live_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !ctl_wr |=> $stable(live_q));

endmodule

// File: rtl/mdm_rx_gate.sv
module mdm_rx_gate #(
    parameter int DATA_W = 8
) (
    input  logic              loop,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    always_comb begin
        out_valid = in_valid & ~loop;
        out_data  = out_valid ? in_data : '0;
    end

    // R8: nothing leaks through in loopback
    always_comb begin
        p_rx_drop_r8: assert (!(loop && out_valid));
    end

endmodule

// File: rtl/mdm_loopback_status.sv
module mdm_loopback_status
    import mdm_pkg::*;
#(
    parameter int                DATA_W     = 8,
    parameter logic [CTRL_W-1:0] RESET_CTRL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic              sts_wr,
    input  logic              sts_rd,
    input  logic [7:0]        wdata,
    input  logic              rx_valid_i,
    input  logic [DATA_W-1:0] rx_data_i,
    output logic [7:0]        ctl_q,
    output logic [7:0]        sts_q,
    output logic              loopback_o,
    output logic              delta_pend_o,
    output logic              rx_valid_o,
    output logic [DATA_W-1:0] rx_data_o
);

    ctrl_t  ctl_nxt;
    ctrl_t  ctl_reg;
    live_t  live;
    delta_t delta;

    mdm_ctrl_reg #(.RESET_CTRL(RESET_CTRL)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .wr    (ctl_wr),
        .wdata (wdata),
        .nxt   (ctl_nxt),
        .q     (ctl_reg)
    );

    mdm_status_reg #(.RESET_CTRL(RESET_CTRL)) u_status (
        .clk     (clk),
        .rst     (rst),
        .ctl_wr  (ctl_wr),
        .ctl_nxt (ctl_nxt),
        .sts_rd  (sts_rd),
        .live_q  (live),
        .delta_q (delta),
        .pend    (delta_pend_o)
    );

    mdm_rx_gate #(.DATA_W(DATA_W)) u_rx_gate (
        .loop      (ctl_reg.loop),
        .in_valid  (rx_valid_i),
        .in_data   (rx_data_i),
        .out_valid (rx_valid_o),
        .out_data  (rx_data_o)
    );

    always_comb begin
        ctl_q      = ctl_reg;
        sts_q      = {live, delta};
        loopback_o = ctl_reg.loop;
    end

    // R9: a status write alone alters nothing
    p_sts_wr_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (sts_wr && !ctl_wr && !sts_rd) |=> ($stable(sts_q) && $stable(ctl_q)));

    // R2: loopback nibble follows control bits after the write
    p_loop_map_r2: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && wdata[4]) |=> (sts_q[7:4] == {$past(wdata[3]), $past(wdata[2]),
                                                 $past(wdata[0]), $past(wdata[1])}));

endmodule

// File: tb/mdm_loopback_status_tb.sv
`timescale 1ns/1ps
module mdm_loopback_status_tb;

    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ctl_wr = 1'b0, sts_wr = 1'b0, sts_rd = 1'b0;
    logic [7:0]        wdata = '0;
    logic              rx_valid_i = 1'b0;
    logic [DATA_W-1:0] rx_data_i = '0;
    logic [7:0]        ctl_q, sts_q;
    logic              loopback_o, delta_pend_o, rx_valid_o;
    logic [DATA_W-1:0] rx_data_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    int m_ctl  = 0;
    int m_sts  = 8'hA0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    mdm_loopback_status #(.DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .sts_wr(sts_wr), .sts_rd(sts_rd),
        .wdata(wdata), .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
        .ctl_q(ctl_q), .sts_q(sts_q), .loopback_o(loopback_o),
        .delta_pend_o(delta_pend_o), .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int live_of(input int c);
        if ((c & 16) == 0) return 8'hA0;
        return ((c & 8) ? 128 : 0) | ((c & 4) ? 64 : 0) |
               ((c & 1) ? 32 : 0)  | ((c & 2) ? 16 : 0);
    endfunction

    // behavioural reference, updated on each edge
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_ctl = 0;
            m_sts = 8'hA0;
        end else begin
            int flags;
            flags = sts_rd ? 0 : (m_sts & 15);
            if (ctl_wr) begin
                int n, o;
                n = live_of(wdata & 31);
                o = m_sts & 8'hF0;
                if ((o ^ n) & 16)  flags |= 1;
                if ((o ^ n) & 32)  flags |= 2;
                if ((o ^ n) & 128) flags |= 8;
                if ((o & 64) && !(n & 64)) flags |= 4;
                m_ctl = wdata & 31;
                m_sts = n | flags;
            end else begin
                m_sts = (m_sts & 8'hF0) | flags;
            end
        end
    end

    // per-cycle comparison away from the edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            int ev, ed;
            ev = (rx_valid_i && !(m_ctl & 16)) ? 1 : 0;
            ed = ev ? int'(rx_data_i) : 0;
            chk(ctl_q == m_ctl[7:0], "R1", ctl_q, m_ctl);
            chk(sts_q == m_sts[7:0], "R6", sts_q, m_sts);
            chk(delta_pend_o == ((m_sts & 15) != 0), "R10", delta_pend_o, (m_sts & 15) != 0);
            chk(rx_valid_o == ev && rx_data_o == ed[DATA_W-1:0], "R8",
                {rx_valid_o, rx_data_o}, {ev[0], ed[DATA_W-1:0]});
        end
    end

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=0", cycles);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic step;
        @(negedge clk); #1;
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        ctl_wr = 1'b1; wdata = v;
        step();
        ctl_wr = 1'b0;
    endtask

    initial begin
        step(); step(); step();
        rst = 1'b0;
        step();
        chk(ctl_q == 8'h00, "R11", ctl_q, 8'h00);
        chk(sts_q == 8'hA0, "R11", sts_q, 8'hA0);
        chk(delta_pend_o == 1'b0, "R10", delta_pend_o, 0);

        wr_ctl(8'hE3);
        chk(ctl_q == 8'h03, "R1", ctl_q, 8'h03);
        chk(sts_q == 8'hA0, "R3", sts_q, 8'hA0);

        wr_ctl(8'h10);
        chk(sts_q == 8'h0A, "R4", sts_q, 8'h0A);
        chk(delta_pend_o == 1'b1, "R10", delta_pend_o, 1);

        wr_ctl(8'h14);
        chk(sts_q == 8'h4A, "R5", sts_q, 8'h4A);

        sts_rd = 1'b1;
        chk(sts_q == 8'h4A, "R7", sts_q, 8'h4A);
        step();
        sts_rd = 1'b0;
        chk(sts_q == 8'h40, "R7", sts_q, 8'h40);

        wr_ctl(8'h10);
        chk(sts_q == 8'h04, "R5", sts_q, 8'h04);

        sts_rd = 1'b1;
        wr_ctl(8'h13);
        sts_rd = 1'b0;
        chk(sts_q == 8'h33, "R2", sts_q, 8'h33);

        sts_wr = 1'b1; wdata = 8'hFF;
        step();
        sts_wr = 1'b0;
        chk(sts_q == 8'h33, "R9", sts_q, 8'h33);
        chk(ctl_q == 8'h13, "R9", ctl_q, 8'h13);

        rx_valid_i = 1'b1; rx_data_i = 8'h5C;
        #0.5;
        chk(rx_valid_o == 1'b0 && rx_data_o == '0, "R8", rx_valid_o, 0);
        wr_ctl(8'h00);
        chk(sts_q == 8'hAB, "R6", sts_q, 8'hAB);
        chk(rx_valid_o == 1'b1 && rx_data_o == 8'h5C, "R8", rx_data_o, 8'h5C);
        rx_valid_i = 1'b0;

        for (int i = 0; i < 400; i++) begin
            ctl_wr     = ($urandom_range(0, 2) == 0);
            sts_rd     = ($urandom_range(0, 4) == 0);
            sts_wr     = ($urandom_range(0, 5) == 0);
            wdata      = 8'($urandom);
            rx_valid_i = $urandom_range(0, 1) == 1;
            rx_data_i  = DATA_W'($urandom);
            step();
        end
        ctl_wr = 1'b0; sts_rd = 1'b0; sts_wr = 1'b0; rx_valid_i = 1'b0;
        step();
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule